// File: doc/BRIEF.md
# Random-Direction Access Memory

This block is a small synchronous memory with a single access strobe and no read/write select. The requester presents an address and a data word. An internal 16-bit pseudo-random sequence then decides whether that access reads the cell or overwrites it. Data in and data out travel on separate buses in the same cycle, so every access returns a word.

A static configuration input sets what a write-type access returns. It can return a fixed constant, echo the incoming word, or return the cell's contents from just before the overwrite. With the last setting, a host can always recover the old value of a cell even when its access turned into a write.

The direction that was chosen appears on a debug output next to the response. It exists only so that the testbench can check the block.

Top module: `rdam_top`

## Requirements
- R1: The direction of each accepted access (`acc_vld`=1) is bit 0 of a 16-bit state register, where 1 means write and 0 means read.
  - After each accepted access the register steps to `{s[14:0], s[15]^s[13]^s[12]^s[10]}`.
  - It does not step on idle cycles.
  - Reset loads it with the SEED parameter (default 16'hACE1). A SEED of zero is replaced by 16'h0001.
- R2: One clock after an accepted access, `rsp_vld` is 1. `rsp_data` and `rsp_wrote` are valid in that same cycle. `rsp_wrote` is 1 when the access acted as a write.
- R3: An access that acts as a read returns the word stored at `acc_addr` and leaves every cell unchanged.
- R4: With `ret_policy`=0, a write stores `acc_wdata` and returns the WR_CONST parameter (default all zeros).
- R5: With `ret_policy`=1, a write stores `acc_wdata` and returns `acc_wdata`.
- R6: With `ret_policy`=2 or 3, a write stores `acc_wdata` and returns the word the cell held just before the write.
- R7: Synchronous active-high reset clears every cell to zero, drives `rsp_vld` low and reloads the direction state from the seed.
- R8: A cycle with `acc_vld`=0 changes no cell and gives `rsp_vld`=0 one clock later.
- R9: The direction state is never all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_vld | input | 1 | Access strobe |
| acc_addr | input | ADDR_W | Cell address |
| acc_wdata | input | DATA_W | Word stored if the access acts as a write |
| ret_policy | input | 2 | Return policy for writes: 0 constant, 1 echo, 2 or 3 prior contents |
| rsp_vld | output | 1 | Response valid, one clock after the access |
| rsp_data | output | DATA_W | Returned word |
| rsp_wrote | output | 1 | Debug: 1 when the access acted as a write |

## Verification
The following are checked by assertions on every cycle:
- the one-cycle response timing and the idle behaviour;
- the debug direction matching the generator's choice;
- the constant and echo return values;
- a nonzero direction state that holds still between accesses.

The following need the bench's scenarios and its reference model of the cells and the sequence:
- that reads leave the storage unchanged;
- that the prior-contents policy returns the overwritten word;
- that the exact direction sequence restarts from the seed after a reset in mid-run.

// File: rtl/rdam_pkg.sv
package rdam_pkg;

    localparam int DIR_STATE_W = 16;

    typedef enum logic [1:0] {
        RET_CONST     = 2'd0,
        RET_ECHO      = 2'd1,
        RET_PRIOR     = 2'd2,
        RET_PRIOR_ALT = 2'd3
    } ret_policy_e;

    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_e;

    // Maximal-length polynomial x^16 + x^14 + x^13 + x^11 + 1
    function automatic logic [DIR_STATE_W-1:0] dir_step(input logic [DIR_STATE_W-1:0] s);
        return {s[DIR_STATE_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/rdam_dir_gen.sv
module rdam_dir_gen
    import rdam_pkg::*;
#(
    parameter logic [DIR_STATE_W-1:0] SEED = 16'hACE1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   adv,
    output dir_e                   dir_o,
    output logic [DIR_STATE_W-1:0] state_o
);
    localparam logic [DIR_STATE_W-1:0] LOAD = (SEED == '0) ? 16'h0001 : SEED;

    logic [DIR_STATE_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LOAD;
        end else if (adv) begin
            state_q <= dir_step(state_q);
        end
    end

    assign dir_o   = state_q[0] ? DIR_WRITE : DIR_READ;
    assign state_o = state_q;
endmodule

// File: rtl/rdam_store.sv
module rdam_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cur_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells_q[i] <= '0;
            end
        end else if (we) begin
            cells_q[addr] <= wdata;
        end
    end

    assign cur_o = cells_q[addr];
endmodule

// File: rtl/rdam_ret_mux.sv
module rdam_ret_mux
    import rdam_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-1:0] WR_CONST = '0
) (
    input  dir_e              dir,
    input  ret_policy_e       policy,
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ret_o
);
    always_comb begin
        ret_o = cur;
        if (dir == DIR_WRITE) begin
            unique case (policy)
                RET_CONST:               ret_o = WR_CONST;
                RET_ECHO:                ret_o = wdata;
                RET_PRIOR, RET_PRIOR_ALT: ret_o = cur;
            endcase
        end
    end
endmodule

// File: rtl/rdam_top.sv
module rdam_top
    import rdam_pkg::*;
#(
    parameter int                     ADDR_W   = 4,
    parameter int                     DATA_W   = 8,
    parameter logic [DIR_STATE_W-1:0] SEED     = 16'hACE1,
    parameter logic [DATA_W-1:0]      WR_CONST = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_vld,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [1:0]        ret_policy,
    output logic              rsp_vld,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_wrote
);
    dir_e                   dir_now;
    logic [DIR_STATE_W-1:0] dir_state;
    logic [DATA_W-1:0]      cur_word;
    logic [DATA_W-1:0]      ret_word;
    logic                   do_write;

    rdam_dir_gen #(.SEED(SEED)) u_dir (
        .clk     (clk),
        .rst     (rst),
        .adv     (acc_vld),
        .dir_o   (dir_now),
        .state_o (dir_state)
    );

    assign do_write = acc_vld && (dir_now == DIR_WRITE);

    rdam_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (do_write),
        .addr  (acc_addr),
        .wdata (acc_wdata),
        .cur_o (cur_word)
    );

    rdam_ret_mux #(.DATA_W(DATA_W), .WR_CONST(WR_CONST)) u_mux (
        .dir    (dir_now),
        .policy (ret_policy_e'(ret_policy)),
        .cur    (cur_word),
        .wdata  (acc_wdata),
        .ret_o  (ret_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld   <= 1'b0;
            rsp_data  <= '0;
            rsp_wrote <= 1'b0;
        end else begin
            rsp_vld <= acc_vld;
            if (acc_vld) begin
                rsp_data  <= ret_word;
                rsp_wrote <= (dir_now == DIR_WRITE);
            end
        end
    end
endmodule

// File: rtl/rdam_chk.sv
module rdam_chk
    import rdam_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-1:0] WR_CONST = '0
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   acc_vld,
    input logic [DATA_W-1:0]      acc_wdata,
    input logic [1:0]             ret_policy,
    input logic                   rsp_vld,
    input logic [DATA_W-1:0]      rsp_data,
    input logic                   rsp_wrote,
    input dir_e                   dir_now,
    input logic [DIR_STATE_W-1:0] dir_state
);
    // R2
    rsp_follows_acc_chk: assert property (@(posedge clk) disable iff (rst)
        acc_vld |=> rsp_vld);

    // R8
    idle_no_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_vld |=> !rsp_vld);

    // R2
    wrote_flag_chk: assert property (@(posedge clk) disable iff (rst)
        acc_vld |=> (rsp_wrote == $past(dir_now == DIR_WRITE)));

    // R4
    const_return_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && dir_now == DIR_WRITE && ret_policy == 2'd0) |=> (rsp_data == WR_CONST));

    // R5
    echo_return_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && dir_now == DIR_WRITE && ret_policy == 2'd1) |=> (rsp_data == $past(acc_wdata)));

    // R1
    state_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_vld |=> $stable(dir_state));

    // R9
    state_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        dir_state != '0);
endmodule

bind rdam_top rdam_chk #(.DATA_W(DATA_W), .WR_CONST(WR_CONST)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_vld    (acc_vld),
    .acc_wdata  (acc_wdata),
    .ret_policy (ret_policy),
    .rsp_vld    (rsp_vld),
    .rsp_data   (rsp_data),
    .rsp_wrote  (rsp_wrote),
    .dir_now    (dir_now),
    .dir_state  (dir_state)
);

// File: tb/rdam_top_bench.sv
`timescale 1ns/1ps
module rdam_top_bench;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam logic [15:0] SEED = 16'hACE1;
    localparam logic [DATA_W-1:0] WR_CONST = '0;

    logic              clk = 1'b0;
    logic              rst;
    logic              acc_vld;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_wdata;
    logic [1:0]        ret_policy;
    logic              rsp_vld;
    logic [DATA_W-1:0] rsp_data;
    logic              rsp_wrote;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    logic [DATA_W-1:0] model_mem [DEPTH];
    logic [15:0]       model_state;

    always #2 clk = ~clk;

    rdam_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEED(SEED), .WR_CONST(WR_CONST)) u_rdam_top (
        .clk        (clk),
        .rst        (rst),
        .acc_vld    (acc_vld),
        .acc_addr   (acc_addr),
        .acc_wdata  (acc_wdata),
        .ret_policy (ret_policy),
        .rsp_vld    (rsp_vld),
        .rsp_data   (rsp_data),
        .rsp_wrote  (rsp_wrote)
    );

    function automatic logic [15:0] next_state(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic [DATA_W-1:0] expect_ret(input logic wr, input logic [1:0] pol,
                                                     input logic [DATA_W-1:0] old,
                                                     input logic [DATA_W-1:0] wd);
        if (!wr)        return old;          // R3
        if (pol == 2'd0) return WR_CONST;    // R4
        if (pol == 2'd1) return wd;          // R5
        return old;                          // R6
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) model_mem[i] = '0;
        model_state = SEED;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; acc_vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("R7 rsp_vld after reset", rsp_vld, 0);
    endtask

    // One access; outputs checked at the negedge after the capturing posedge
    task automatic access(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        logic wr;
        logic [DATA_W-1:0] exp;
        string tag;
        @(negedge clk);
        acc_vld = 1'b1; acc_addr = a; acc_wdata = d;
        wr  = model_state[0];
        exp = expect_ret(wr, ret_policy, model_mem[a], d);
        if (!wr) tag = "R3 read data";
        else if (ret_policy == 2'd0) tag = "R4 const return";
        else if (ret_policy == 2'd1) tag = "R5 echo return";
        else tag = "R6 prior return";
        if (wr) model_mem[a] = d;
        model_state = next_state(model_state);
        @(negedge clk);
        acc_vld = 1'b0;
        check("R2 rsp_vld", rsp_vld, 1);
        check("R1 direction", rsp_wrote, wr);
        check(tag, rsp_data, exp);
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        acc_vld = 1'b0; acc_wdata = 8'hFF;
        @(negedge clk);
        check("R8 idle rsp_vld", rsp_vld, 0);
    endtask

    initial begin
        int unsigned r;
        rst = 1'b1; acc_vld = 1'b0; acc_addr = '0; acc_wdata = '0; ret_policy = 2'd2;
        r = $urandom(32'd4242);
        do_reset();

        // R7: every cell reads as zero (prior policy returns zero on writes too)
        for (int i = 0; i < DEPTH; i++) access(ADDR_W'(i), 8'hA5);

        // Random traffic under each policy, including the alias code 3 (R6)
        for (int p = 0; p < 4; p++) begin
            ret_policy = 2'(p);
            for (int k = 0; k < 300; k++) begin
                r = $urandom;
                if (r[3:0] == 4'd0) idle_cycle();   // R8, R1 state holds over idle
                access(ADDR_W'(r[11:8]), DATA_W'(r[23:16]));
            end
        end

        // Directed corners: same cell back to back, extreme data words
        ret_policy = 2'd2;
        for (int k = 0; k < 20; k++) access('1, (k % 2) ? 8'hFF : 8'h00);
        ret_policy = 2'd1;
        for (int k = 0; k < 10; k++) access('0, 8'h80 + 8'(k));

        // R7: mid-run reset restarts sequence from seed and clears cells; R9 long run above
        do_reset();
        ret_policy = 2'd2;
        for (int i = 0; i < DEPTH; i++) access(ADDR_W'(i), 8'h3C);
        ret_policy = 2'd0;
        for (int k = 0; k < 40; k++) begin
            r = $urandom;
            access(ADDR_W'(r[3:0]), DATA_W'(r[15:8]));
        end
        idle_cycle();

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule